// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block carries out trap entry for a hart that runs in machine, supervisor and user modes. One single-cycle strobe delivers a trap with its cause code, an interrupt flag, the faulting address and the program counter. On the following clock edge the block decides whether the supervisor or the machine level handles the trap. It then saves the interrupt-enable stack and previous privilege for that level, and writes that level's cause, exception-PC and trap-value registers. It also switches the privilege, drops any load reservation and issues a one-cycle redirect to the handler address.

The delegation masks and the two trap-vector bases come from the surrounding control-register file as plain inputs. A small context-write port lets that file set the current privilege and the two global interrupt enables. A reservation-set input marks a load-reserved access. The exception-return path and the hypervisor extension belong to other blocks.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the privilege is machine (3). All enable, previous-enable and previous-privilege fields are 0. The cause, exception-PC and trap-value registers of both levels are 0, and the redirect and reservation outputs are low.
- R2: A trap goes to supervisor level only when the current privilege is user (0) or supervisor (1) and bit `code` of the delegation mask is set. The mask is the interrupt mask for interrupts and the exception mask for synchronous traps. Every other trap goes to machine level.
- R3: On supervisor entry, the supervisor previous-enable takes the old supervisor enable, the supervisor previous-privilege bit takes bit 0 of the old privilege, and the supervisor enable is cleared. The machine-level registers keep their values.
- R4: On machine entry, the machine previous-enable takes the old machine enable, the machine previous-privilege field takes the old privilege, and the machine enable is cleared. The supervisor-level registers keep their values.
- R5: The target cause register receives the code in its low bits, with bit XLEN-1 set for an interrupt and all other bits zero. The target exception-PC register receives the trap PC.
- R6: The target trap-value register receives the faulting address only for synchronous codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other synchronous code and for every interrupt it receives zero.
- R7: A synchronous trap with code 8 is treated as an environment call. Its code becomes 8, 9 or 11 for a current privilege of user, supervisor or machine, and the new code is used for delegation and for the cause register.
- R8: One cycle after the strobe, `redirect_o` is high for exactly one cycle. `redirect_pc_o` then holds the target vector base with its two low bits cleared. When the base's low two bits equal 1 and the trap is an interrupt, 4 times the code is added to that value.
- R9: After entry the privilege equals the target level (1 or 3), and the reservation output is low even when a reservation was set in the same cycle as the trap.
- R10: Without a trap, a context write loads the privilege and both enables, and the reserved privilege value 2 is stored as user. When a trap and a context write arrive together, the trap wins.
- R11: Every entry update is visible in the cycle right after the strobe. Cycles without a strobe or a context write leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Single-cycle trap strobe |
| trap_async_i | input | 1 | Trap is an interrupt |
| trap_code_i | input | CODE_W | Cause code |
| trap_addr_i | input | XLEN | Faulting address |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor vector base and mode |
| mtvec_i | input | XLEN | Machine vector base and mode |
| ctx_wr_i | input | 1 | Context write strobe |
| ctx_priv_i | input | 2 | Privilege to load |
| ctx_sie_i | input | 1 | Supervisor enable to load |
| ctx_mie_i | input | 1 | Machine enable to load |
| resv_set_i | input | 1 | Set the load reservation |
| priv_o | output | 2 | Current privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | XLEN | Handler address |
| resv_valid_o | output | 1 | Load reservation held |

## Verification
The bench aims at delegated causes raised from machine mode. A design that ignored the privilege condition would wrongly enter supervisor level there. It also fires environment calls from each privilege with only the rewritten code delegated; delegating on the raw code would route the trap to the wrong level. Vectored bases receive synchronous traps, where adding the offset anyway would shift the handler address. A trap collides with a context write and with a reservation set in the same cycle, which shows whether the trap gets priority. The reserved privilege value and random interrupt codes whose numbers match address-carrying exceptions show whether trap-value capture wrongly follows the code alone.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int unsigned ECALL_GEN = 8;
  localparam int unsigned ECALL_U   = 8;
  localparam int unsigned ECALL_S   = 9;
  localparam int unsigned ECALL_M   = 11;
  localparam logic [1:0]  VEC_MODE_IRQ = 2'd1;

  // synchronous causes that carry an address
  function automatic logic code_has_addr(input int unsigned code);
    case (code)
      0, 1, 4, 5, 6, 7, 12, 13, 15: code_has_addr = 1'b1;
      default:                      code_has_addr = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
  import trap_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              async_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  output logic [CODE_W-1:0] code_o,
  output logic              tval_en_o
);
  logic is_ecall;

  assign is_ecall = !async_i && (code_i == CODE_W'(ECALL_GEN));

  always_comb begin
    code_o = code_i;
    if (is_ecall) begin
      case (priv_i)
        PRIV_M:  code_o = CODE_W'(ECALL_M);
        PRIV_S:  code_o = CODE_W'(ECALL_S);
        default: code_o = CODE_W'(ECALL_U);
      endcase
    end
  end

  assign tval_en_o = !async_i && code_has_addr(int'(code_i));
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              async_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  output logic              to_s_o
);
  logic [XLEN-1:0] mask;
  logic            low_priv;

  assign mask     = async_i ? mideleg_i : medeleg_i;
  assign low_priv = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign to_s_o   = low_priv && mask[code_i];
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5,
  parameter bit          VEC_EN = 1'b1
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic              async_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   pc_o
);
  localparam int unsigned PAD_W = XLEN - CODE_W - 2;

  logic [XLEN-1:0] aligned;
  logic [XLEN-1:0] offset;

  assign aligned = {base_i[XLEN-1:2], 2'b00};

  generate
    if (VEC_EN) begin : g_vec
      logic use_off;
      assign use_off = async_i && (base_i[1:0] == VEC_MODE_IRQ);
      assign offset  = use_off ? {{PAD_W{1'b0}}, code_i, 2'b00} : '0;
    end else begin : g_direct
      assign offset = '0;
    end
  endgenerate

  assign pc_o = aligned + offset;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter bit          VEC_EN = 1'b1,
  localparam int unsigned CODE_W = $clog2(XLEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_valid_i,
  input  logic              trap_async_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [XLEN-1:0]   trap_addr_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic              ctx_wr_i,
  input  logic [1:0]        ctx_priv_i,
  input  logic              ctx_sie_i,
  input  logic              ctx_mie_i,
  input  logic              resv_set_i,
  output logic [1:0]        priv_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic              spp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic [1:0]        mpp_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              resv_valid_o
);
  localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

  logic [1:0]        priv_q;
  logic              sie_q, spie_q, spp_q, mie_q, mpie_q;
  logic [1:0]        mpp_q;
  logic [XLEN-1:0]   scause_q, sepc_q, stval_q;
  logic [XLEN-1:0]   mcause_q, mepc_q, mtval_q;
  logic              redir_q, resv_q;
  logic [XLEN-1:0]   redir_pc_q;

  logic [CODE_W-1:0] code_fix;
  logic              tval_en, to_s;
  logic [XLEN-1:0]   tvec, handler_pc, cause_word, tval_word;
  logic [1:0]        ctx_priv_legal;

  trap_cause_fix #(.CODE_W(CODE_W)) u_fix (
    .async_i   (trap_async_i),
    .code_i    (trap_code_i),
    .priv_i    (priv_q),
    .code_o    (code_fix),
    .tval_en_o (tval_en)
  );

  trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
    .async_i   (trap_async_i),
    .code_i    (code_fix),
    .priv_i    (priv_q),
    .medeleg_i (medeleg_i),
    .mideleg_i (mideleg_i),
    .to_s_o    (to_s)
  );

  assign tvec = to_s ? stvec_i : mtvec_i;

  trap_vector #(.XLEN(XLEN), .CODE_W(CODE_W), .VEC_EN(VEC_EN)) u_vec (
    .base_i  (tvec),
    .async_i (trap_async_i),
    .code_i  (code_fix),
    .pc_o    (handler_pc)
  );

  assign cause_word     = {trap_async_i, {PAD_W{1'b0}}, code_fix};
  assign tval_word      = tval_en ? trap_addr_i : '0;
  assign ctx_priv_legal = (ctx_priv_i == PRIV_RSV) ? PRIV_U : ctx_priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q     <= PRIV_M;
      sie_q      <= 1'b0;
      spie_q     <= 1'b0;
      spp_q      <= 1'b0;
      mie_q      <= 1'b0;
      mpie_q     <= 1'b0;
      mpp_q      <= PRIV_U;
      scause_q   <= '0;
      sepc_q     <= '0;
      stval_q    <= '0;
      mcause_q   <= '0;
      mepc_q     <= '0;
      mtval_q    <= '0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= trap_valid_i;
      if (trap_valid_i) begin
        redir_pc_q <= handler_pc;
        if (to_s) begin
          spie_q   <= sie_q;
          spp_q    <= priv_q[0];
          sie_q    <= 1'b0;
          scause_q <= cause_word;
          sepc_q   <= trap_pc_i;
          stval_q  <= tval_word;
          priv_q   <= PRIV_S;
        end else begin
          mpie_q   <= mie_q;
          mpp_q    <= priv_q;
          mie_q    <= 1'b0;
          mcause_q <= cause_word;
          mepc_q   <= trap_pc_i;
          mtval_q  <= tval_word;
          priv_q   <= PRIV_M;
        end
      end else if (ctx_wr_i) begin
        priv_q <= ctx_priv_legal;
        sie_q  <= ctx_sie_i;
        mie_q  <= ctx_mie_i;
      end
    end
  end

  // trap drops the reservation even against a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           resv_q <= 1'b0;
    else if (trap_valid_i) resv_q <= 1'b0;
    else if (resv_set_i)   resv_q <= 1'b1;
  end

  assign priv_o        = priv_q;
  assign sie_o         = sie_q;
  assign spie_o        = spie_q;
  assign spp_o         = spp_q;
  assign mie_o         = mie_q;
  assign mpie_o        = mpie_q;
  assign mpp_o         = mpp_q;
  assign scause_o      = scause_q;
  assign sepc_o        = sepc_q;
  assign stval_o       = stval_q;
  assign mcause_o      = mcause_q;
  assign mepc_o        = mepc_q;
  assign mtval_o       = mtval_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;
  assign resv_valid_o  = resv_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_valid_i,
  input logic              trap_async_i,
  input logic [CODE_W-1:0] trap_code_i,
  input logic [XLEN-1:0]   trap_pc_i,
  input logic [XLEN-1:0]   mideleg_i,
  input logic              ctx_wr_i,
  input logic [1:0]        priv_o,
  input logic              sie_o,
  input logic              spie_o,
  input logic              spp_o,
  input logic              mie_o,
  input logic              mpie_o,
  input logic [1:0]        mpp_o,
  input logic [XLEN-1:0]   mcause_o,
  input logic [XLEN-1:0]   mepc_o,
  input logic              redirect_o,
  input logic              resv_valid_o
);
  a_r9_priv_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o != 2'd2);

  a_r2_irq_undelegated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_async_i && !mideleg_i[trap_code_i] |=> priv_o == 2'd3);

  a_r2_from_m_stays_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_o == 2'd3 |=> priv_o == 2'd3);

  a_r4_m_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_o == 2'd3 |=> !mie_o && mpp_o == 2'd3 && mpie_o == $past(mie_o));

  a_r4_s_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_o == 2'd3 |=> $stable(sie_o) && $stable(spie_o) && $stable(spp_o));

  a_r5_m_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_o == 2'd3 |=>
      mepc_o == $past(trap_pc_i) && mcause_o[XLEN-1] == $past(trap_async_i));

  a_r8_redirect_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> redirect_o);

  a_r8_no_spurious_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> !redirect_o);

  a_r9_resv_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> !resv_valid_o);

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i && !ctx_wr_i |=>
      $stable(priv_o) && $stable(mcause_o) && $stable(mepc_o) && $stable(mie_o) && $stable(sie_o));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_valid_i (trap_valid_i),
  .trap_async_i (trap_async_i),
  .trap_code_i  (trap_code_i),
  .trap_pc_i    (trap_pc_i),
  .mideleg_i    (mideleg_i),
  .ctx_wr_i     (ctx_wr_i),
  .priv_o       (priv_o),
  .sie_o        (sie_o),
  .spie_o       (spie_o),
  .spp_o        (spp_o),
  .mie_o        (mie_o),
  .mpie_o       (mpie_o),
  .mpp_o        (mpp_o),
  .mcause_o     (mcause_o),
  .mepc_o       (mepc_o),
  .redirect_o   (redirect_o),
  .resv_valid_o (resv_valid_o)
);

// File: tb/trap_entry_ctrl_test.sv
`timescale 1ns/1ps
module trap_entry_ctrl_test;
  localparam int unsigned XLEN = 32;
  localparam int unsigned CW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            trap_valid = 0, trap_async = 0;
  logic [CW-1:0]   trap_code = '0;
  logic [XLEN-1:0] trap_addr = '0, trap_pc = '0;
  logic [XLEN-1:0] medeleg = '0, mideleg = '0, stvec = '0, mtvec = '0;
  logic            ctx_wr = 0, ctx_sie = 0, ctx_mie = 0, resv_set = 0;
  logic [1:0]      ctx_priv = '0;

  logic [1:0]      priv, mpp;
  logic            sie, spie, spp, mie, mpie, redirect, resv_valid;
  logic [XLEN-1:0] scause, sepc, stval, mcause, mepc, mtval, redirect_pc;

  trap_entry_ctrl #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_valid_i(trap_valid), .trap_async_i(trap_async), .trap_code_i(trap_code),
    .trap_addr_i(trap_addr), .trap_pc_i(trap_pc),
    .medeleg_i(medeleg), .mideleg_i(mideleg), .stvec_i(stvec), .mtvec_i(mtvec),
    .ctx_wr_i(ctx_wr), .ctx_priv_i(ctx_priv), .ctx_sie_i(ctx_sie), .ctx_mie_i(ctx_mie),
    .resv_set_i(resv_set),
    .priv_o(priv), .sie_o(sie), .spie_o(spie), .spp_o(spp), .mie_o(mie), .mpie_o(mpie),
    .mpp_o(mpp), .scause_o(scause), .sepc_o(sepc), .stval_o(stval),
    .mcause_o(mcause), .mepc_o(mepc), .mtval_o(mtval),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .resv_valid_o(resv_valid)
  );

  // bench model of architectural state
  logic [1:0]      e_priv = 2'd3, e_mpp = 2'd0;
  logic            e_sie = 0, e_spie = 0, e_spp = 0, e_mie = 0, e_mpie = 0, e_resv = 0;
  logic [XLEN-1:0] e_scause = 0, e_sepc = 0, e_stval = 0, e_mcause = 0, e_mepc = 0, e_mtval = 0;
  logic [XLEN-1:0] e_rpc = 0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit addr_code(input int c);
    return (c inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
  endfunction

  task automatic check_state(input string ctx);
    chk({"R9 priv ", ctx}, priv, e_priv);
    chk({"R3 sie ", ctx}, sie, e_sie);
    chk({"R3 spie ", ctx}, spie, e_spie);
    chk({"R3 spp ", ctx}, spp, e_spp);
    chk({"R4 mie ", ctx}, mie, e_mie);
    chk({"R4 mpie ", ctx}, mpie, e_mpie);
    chk({"R4 mpp ", ctx}, mpp, e_mpp);
    chk({"R5 scause ", ctx}, scause, e_scause);
    chk({"R5 sepc ", ctx}, sepc, e_sepc);
    chk({"R6 stval ", ctx}, stval, e_stval);
    chk({"R5 mcause ", ctx}, mcause, e_mcause);
    chk({"R5 mepc ", ctx}, mepc, e_mepc);
    chk({"R6 mtval ", ctx}, mtval, e_mtval);
    chk({"R9 resv ", ctx}, resv_valid, e_resv);
  endtask

  // model a trap entry (R2..R9)
  task automatic model_trap(input bit as, input int code_in, input logic [XLEN-1:0] addr,
                            input logic [XLEN-1:0] pc);
    int c;
    bit dl, to_s;
    logic [XLEN-1:0] base, cw, tv;
    c = code_in;
    if (!as && c == 8) c = (e_priv == 2'd0) ? 8 : (e_priv == 2'd1) ? 9 : 11; // R7
    dl = as ? mideleg[c] : medeleg[c];
    to_s = (e_priv <= 2'd1) && dl;
    base = to_s ? stvec : mtvec;
    e_rpc = {base[XLEN-1:2], 2'b00} + ((as && base[1:0] == 2'd1) ? XLEN'(c * 4) : '0);
    cw = {as, 26'd0, c[CW-1:0]};
    tv = (!as && addr_code(code_in)) ? addr : '0;
    if (to_s) begin
      e_spie = e_sie; e_spp = e_priv[0]; e_sie = 0;
      e_scause = cw; e_sepc = pc; e_stval = tv; e_priv = 2'd1;
    end else begin
      e_mpie = e_mie; e_mpp = e_priv; e_mie = 0;
      e_mcause = cw; e_mepc = pc; e_mtval = tv; e_priv = 2'd3;
    end
    e_resv = 0;
  endtask

  task automatic do_ctx(input logic [1:0] p, input bit s, input bit m);
    @(negedge clk);
    ctx_wr = 1; ctx_priv = p; ctx_sie = s; ctx_mie = m;
    @(negedge clk);
    ctx_wr = 0;
    e_priv = (p == 2'd2) ? 2'd0 : p; e_sie = s; e_mie = m;
    check_state("R10 ctx write");
  endtask

  task automatic do_resv();
    @(negedge clk);
    resv_set = 1;
    @(negedge clk);
    resv_set = 0;
    e_resv = 1;
    chk("R9 resv set", resv_valid, 1'b1);
  endtask

  task automatic do_trap(input bit as, input int code, input logic [XLEN-1:0] addr,
                         input logic [XLEN-1:0] pc, input bit with_ctx, input bit with_resv,
                         input string ctx);
    @(negedge clk);
    trap_valid = 1; trap_async = as; trap_code = CW'(code);
    trap_addr = addr; trap_pc = pc;
    ctx_wr = with_ctx; ctx_priv = 2'd0; ctx_sie = 1; ctx_mie = 1;
    resv_set = with_resv;
    model_trap(as, code, addr, pc);
    @(negedge clk);
    trap_valid = 0; ctx_wr = 0; resv_set = 0;
    check_state(ctx);
    chk({"R8 redirect ", ctx}, redirect, 1'b1);
    chk({"R8 redirect pc ", ctx}, redirect_pc, e_rpc);
    @(negedge clk);
    chk({"R8 redirect drop ", ctx}, redirect, 1'b0);
    check_state({"R11 hold ", ctx});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    chk("R1 redirect", redirect, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 after reset");

    // R2: delegated cause raised from M stays in M
    medeleg = 32'hFFFF_FFFF; mideleg = 32'hFFFF_FFFF;
    stvec = 32'h0000_4001; mtvec = 32'h0000_8001;
    do_trap(0, 2, 32'h11, 32'h100, 0, 0, "R2 from M");
    // R7: ecall rewriting, only rewritten code delegated
    medeleg = 32'h0000_0200;              // only code 9
    do_ctx(2'd1, 1, 1);
    do_trap(0, 8, 32'h22, 32'h200, 0, 0, "R7 ecall S");
    do_ctx(2'd0, 0, 1);
    do_trap(0, 8, 32'h33, 32'h300, 0, 0, "R7 ecall U");
    do_trap(0, 8, 32'h44, 32'h400, 0, 0, "R7 ecall M");
    // R8: vectored base with synchronous trap gets no offset
    medeleg = 32'h0000_0020;
    do_ctx(2'd0, 1, 0);
    do_trap(0, 5, 32'hABCD, 32'h500, 0, 0, "R8 sync vectored");
    // R8: interrupt with vectored mode
    mideleg = 32'h0000_0020;
    do_ctx(2'd1, 1, 1);
    do_trap(1, 5, 32'hDEAD, 32'h600, 0, 0, "R6 R8 irq vectored");
    // R10: reserved priv maps to U
    do_ctx(2'd2, 0, 0);
    // R10 R9: collision with ctx write and reservation set
    do_resv();
    do_trap(0, 3, 32'h77, 32'h700, 1, 1, "R10 collision");

    for (int i = 0; i < 400; i++) begin
      int sel;
      bit as;
      int code;
      sel = int'($urandom_range(0, 3));
      if (sel == 0) begin
        int pk;
        pk = int'($urandom_range(0, 3));
        do_ctx(2'(pk), 1'($urandom), 1'($urandom));
      end else if (sel == 1) begin
        do_resv();
      end
      medeleg = $urandom; mideleg = $urandom;
      stvec = $urandom; mtvec = $urandom;
      as = 1'($urandom);
      code = as ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 15));
      do_trap(as, code, $urandom, $urandom, 1'($urandom_range(0, 7) == 0),
              1'($urandom_range(0, 3) == 0), "R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule